// File: doc/BRIEF.md
# Edge-Triggered Interrupt Pending Controller

This block sits beside a small processor core and turns a bank of external interrupt lines into one vectored request. Every line is resampled into the core clock domain and watched for a low-to-high transition. Each transition is latched in a single pending bit for that line. The bit is kept even while the core runs with interrupts masked. A second transition that arrives before the bit is consumed merges into the same bit. No queue of repeated events is built.

The core sees a request flag and a source index. The index names the lowest-numbered pending line. The request is shown only while the global enable is on and no post-return blocking window is open. When the core takes the request, the block clears that line's pending bit and turns the global enable off. A return strobe turns the enable back on. After a return, one main-line instruction must retire before the next request is shown. Main-line code can also switch the enable on and off, and can drop pending bits through a clear mask.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, req_o is 0 and gie_o is 0, and every pending bit is clear.
- R2: Each line passes through two sampling flops before edge detection. With the enable on and no blocking window, a rise driven just before clock edge k makes req_o read 1 after edge k+2. The request then shows that line's index.
- R3: A rise sets its pending bit even while gie_o is 0. The request appears once the enable is switched on.
- R4: A line held high sets its bit only once. Several rises before the bit is cleared leave exactly one pending request.
- R5: Among pending bits, the lowest index wins. req_idx_o carries that index while req_o is 1.
- R6: When ack_i is high in a cycle where req_o is 1, the bit of req_idx_o is cleared and gie_o becomes 0 at the next edge. When req_o is 0, ack_i changes nothing.
- R7: ret_i sets gie_o and opens a blocking window. While the window is open, req_o stays 0. The window closes at the edge where retire_i is high, so req_o may rise in the cycle after that retire.
- R8: A rise on a line whose bit was cleared on entry to its handler makes that request appear again after the return and the one retire.
- R9: If a rise on a line and the clearing of that line's bit fall in the same cycle, the bit stays set.
- R10: With SW_CLR_EN=1, each bit set in sw_clr_i clears that pending bit at the next edge, unless a rise sets it in the same cycle.
- R11: gie_set_i sets gie_o and gie_clr_i clears it. Priority order is: an accepted ack (clears), then ret_i (sets), then gie_clr_i, then gie_set_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | N_SRC | External interrupt lines, asynchronous |
| retire_i | input | 1 | Main-line instruction retired this cycle |
| ack_i | input | 1 | Core enters the handler of req_idx_o |
| ret_i | input | 1 | Core returns from a handler |
| gie_set_i | input | 1 | Software turns global enable on |
| gie_clr_i | input | 1 | Software turns global enable off |
| sw_clr_i | input | N_SRC | Software mask of pending bits to clear |
| req_o | output | 1 | Interrupt request to the core |
| req_idx_o | output | IDX_W | Index of the requested source |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
Single clean rises check the three-edge latency and the reported index. Pairs of rises taken while masked show that pending bits survive masking and drain in priority order. Bursts of rises during a handler tell a merged single bit apart from a queue, because they must cause exactly one re-entry. A rise timed onto the ack cycle of the same line shows that setting beats clearing. A long run of random line toggles mixed with random retire, ack, return and enable strobes is compared each cycle against a reference model. That run exposes mistakes in the blocking window and the priority order that the directed cases miss.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
   typedef enum logic [1:0] {
      GIE_KEEP = 2'd0,
      GIE_ON   = 2'd1,
      GIE_OFF  = 2'd2
   } gie_op_e;
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det #(
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] lines_i,
   output logic [N_SRC-1:0] rise_o
);
   localparam int LAST = SYNC_STAGES - 1;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0] stage_q [SYNC_STAGES];
   logic [N_SRC-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[0] <= '0;
      else         stage_q[0] <= lines_i;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q[s] <= '0;
         else         stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= stage_q[LAST];
   end

   assign rise_o = stage_q[LAST] & ~prev_q;

   // A rise lasts one cycle: the next cycle it is seen as the previous sample
   a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
   parameter int N_SRC = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flags_o
);
   logic [N_SRC-1:0] flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_chk
      a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[i] |=> flags_o[i]);
      a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
   end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel #(
   parameter int N_SRC = 8,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] flags_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (flags_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |flags_i;

   always_comb begin
      if (any_o) begin
         a_r5_lowest_wins: assert (flags_i[idx_o] &&
            ((flags_i & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0));
      end
   end
endmodule

// File: rtl/irq_pend_ctrl.sv
`timescale 1ns/1ps
module irq_pend_ctrl #(
   parameter int N_SRC       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SW_CLR_EN   = 1'b1,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] irq_lines_i,
   input  logic             retire_i,
   input  logic             ack_i,
   input  logic             ret_i,
   input  logic             gie_set_i,
   input  logic             gie_clr_i,
   input  logic [N_SRC-1:0] sw_clr_i,
   output logic             req_o,
   output logic [IDX_W-1:0] req_idx_o,
   output logic             gie_o
);
   import irq_pkg::*;

   initial begin
      assert (N_SRC >= 2 && N_SRC <= 64) else $error("N_SRC out of range");
   end

   logic [N_SRC-1:0] rise;
   logic [N_SRC-1:0] flags;
   logic [N_SRC-1:0] clr_mask;
   logic [N_SRC-1:0] sw_mask;
   logic [IDX_W-1:0] sel_idx;
   logic             any_pend;
   logic             take;
   logic             gie_q;
   logic             gap_q;
   gie_op_e          gie_op;

   irq_edge_det #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lines_i (irq_lines_i),
      .rise_o  (rise)
   );

   irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (rise),
      .clr_i   (clr_mask),
      .flags_o (flags)
   );

   irq_prio_sel #(.N_SRC(N_SRC)) u_sel (
      .flags_i (flags),
      .any_o   (any_pend),
      .idx_o   (sel_idx)
   );

   if (SW_CLR_EN) begin : g_swclr
      assign sw_mask = sw_clr_i;
   end else begin : g_noswclr
      assign sw_mask = '0;
   end

   assign req_o     = any_pend & gie_q & ~gap_q;
   assign req_idx_o = sel_idx;
   assign take      = ack_i & req_o;
   assign clr_mask  = (take ? (N_SRC'(1) << sel_idx) : '0) | sw_mask;
   assign gie_o     = gie_q;

   always_comb begin
      if (take)           gie_op = GIE_OFF;
      else if (ret_i)     gie_op = GIE_ON;
      else if (gie_clr_i) gie_op = GIE_OFF;
      else if (gie_set_i) gie_op = GIE_ON;
      else                gie_op = GIE_KEEP;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q <= 1'b0;
      end else begin
         case (gie_op)
            GIE_ON:  gie_q <= 1'b1;
            GIE_OFF: gie_q <= 1'b0;
            default: gie_q <= gie_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       gap_q <= 1'b0;
      else if (ret_i)    gap_q <= 1'b1;
      else if (retire_i) gap_q <= 1'b0;
   end

   a_r6_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && req_o) |=> !gie_o);
   a_r7_return_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !(ack_i && req_o)) |=> gie_o);
   a_r7_gap_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i |=> !req_o);
   a_r3_masked_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gie_o |-> !req_o);
   a_r11_clr_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gie_clr_i && !ret_i) |=> !gie_o);
endmodule

// File: tb/irq_pend_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb;
   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  lines = '0;
   logic          retire = 1'b0, ack = 1'b0, ret = 1'b0, gset = 1'b0, gclr = 1'b0;
   logic [N-1:0]  swclr = '0;
   logic          req;
   logic [IW-1:0] idx;
   logic          gie;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   irq_pend_ctrl #(.N_SRC(N), .SYNC_STAGES(2), .SW_CLR_EN(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .retire_i(retire),
      .ack_i(ack), .ret_i(ret), .gie_set_i(gset), .gie_clr_i(gclr),
      .sw_clr_i(swclr), .req_o(req), .req_idx_o(idx), .gie_o(gie)
   );

   // reference model
   logic [N-1:0] m_s1 = '0, m_s2 = '0, m_p = '0, m_flag = '0;
   logic         m_gie = 1'b0, m_gap = 1'b0;

   function automatic logic [IW-1:0] lowest(input logic [N-1:0] f);
      for (int i = 0; i < N; i++) if (f[i]) return IW'(i);
      return '0;
   endfunction

   function automatic logic exp_req();
      return (m_flag != '0) && m_gie && !m_gap;
   endfunction

   task automatic model_step();
      logic [N-1:0] rise_v, clr_v;
      logic         tk;
      rise_v = m_s2 & ~m_p;
      tk     = ack && exp_req();
      clr_v  = (tk ? (N'(1) << lowest(m_flag)) : '0) | swclr;
      m_flag = (m_flag & ~clr_v) | rise_v;
      if (tk)        m_gie = 1'b0;
      else if (ret)  m_gie = 1'b1;
      else if (gclr) m_gie = 1'b0;
      else if (gset) m_gie = 1'b1;
      if (ret)         m_gap = 1'b1;
      else if (retire) m_gap = 1'b0;
      m_p  = m_s2;
      m_s2 = m_s1;
      m_s1 = lines;
   endtask

   task automatic check(input string tag);
      logic er;
      er = exp_req();
      checks++;
      if (req !== er || gie !== m_gie || (er && idx !== lowest(m_flag))) begin
         fails++;
         $display("FAIL %s: req=%0b idx=%0d gie=%0b expected req=%0b idx=%0d gie=%0b",
                  tag, req, idx, gie, er, lowest(m_flag), m_gie);
      end
   endtask

   task automatic check_val(input string tag, input logic a_req, input int a_idx,
                            input logic e_req, input int e_idx);
      checks++;
      if (a_req !== e_req || (e_req && a_idx != e_idx)) begin
         fails++;
         $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                  tag, a_req, a_idx, e_req, e_idx);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag);
      retire = 0; ack = 0; ret = 0; gset = 0; gclr = 0; swclr = '0;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int k = 0; k < n; k++) tick(tag);
   endtask

   task automatic pulse(input int src, input string tag);
      lines[src] = 1'b1; ticks(2, tag);
      lines[src] = 1'b0; ticks(2, tag);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset");
      check_val("R1 reset req", req, idx, 1'b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      gset = 1; tick("R11 enable on");
      check_val("R11 gie set", gie, 0, 1'b1, 0);

      // R2 latency: rise driven before edge k, request after k+2
      lines[3] = 1; tick("R2 edge k");
      check_val("R2 not yet at k", req, idx, 1'b0, 0);
      tick("R2 edge k+1");
      check_val("R2 not yet at k+1", req, idx, 1'b0, 0);
      tick("R2 edge k+2");
      check_val("R2 request at k+2", req, idx, 1'b1, 3);

      // R6 entry, R12-like level hold handled by R4: no refire while held
      ack = 1; tick("R6 ack");
      check_val("R6 gie cleared", gie, 0, 1'b0, 0);
      ticks(4, "R4 level held");
      ret = 1; tick("R7 return");
      check_val("R7 blocked after return", req, idx, 1'b0, 0);
      retire = 1; tick("R7 retire");
      check_val("R4 held level no second request", req, idx, 1'b0, 0);
      lines[3] = 0; ticks(3, "R4 release");

      // R3 and R5: two rises while masked, lowest wins when enabled
      gclr = 1; tick("R11 disable");
      pulse(5, "R3 masked rise 5");
      pulse(2, "R3 masked rise 2");
      check_val("R3 masked no req", req, idx, 1'b0, 0);
      gset = 1; tick("R3 enable");
      check_val("R5 lowest first", req, idx, 1'b1, 2);
      ack = 1; tick("R6 ack 2");
      ack = 1; tick("R6 ack ignored while masked");

      // R8 and R4: three rises on line 1 inside the handler
      pulse(1, "R8 rise in handler");
      pulse(1, "R4 second rise");
      pulse(1, "R4 third rise");
      ret = 1; tick("R7 return 2");
      check_val("R7 gap holds", req, idx, 1'b0, 0);
      tick("R7 gap holds without retire");
      check_val("R7 still blocked", req, idx, 1'b0, 0);
      retire = 1; tick("R7 retire 2");
      check_val("R8 re-entry lowest 1", req, idx, 1'b1, 1);
      ack = 1; tick("R6 ack 1");
      ret = 1; tick("R7 return 3");
      retire = 1; tick("R7 retire 3");
      check_val("R4 merged to one, next is 5", req, idx, 1'b1, 5);

      // R9: rise on line 0 lands in the cycle its bit is cleared
      ack = 1; tick("R6 ack 5");
      ret = 1; tick("R7 ret 4");
      retire = 1; tick("R7 retire 4");
      pulse(0, "R9 setup");
      check_val("R9 pending 0", req, idx, 1'b1, 0);
      lines[0] = 1; tick("R9 rise a");
      tick("R9 rise b");
      ack = 1; tick("R9 ack with rise");
      lines[0] = 0;
      ret = 1; tick("R9 ret");
      retire = 1; tick("R9 retire");
      check_val("R9 set won over clear", req, idx, 1'b1, 0);

      // R10 software clear
      swclr = 8'h01; tick("R10 sw clear");
      check_val("R10 cleared", req, idx, 1'b0, 0);

      // random run against the model
      void'($urandom(32'h1234_5678));
      for (int c = 0; c < 4000; c++) begin
         for (int b = 0; b < N; b++) if ($urandom_range(0, 9) == 0) lines[b] = ~lines[b];
         retire = ($urandom_range(0, 1) == 1);
         ack    = ($urandom_range(0, 4) == 0);
         ret    = ($urandom_range(0, 9) == 0);
         gset   = ($urandom_range(0, 19) == 0);
         gclr   = ($urandom_range(0, 39) == 0);
         swclr  = ($urandom_range(0, 29) == 0) ? N'($urandom) : '0;
         tick("R5 R7 R11 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule